// File: doc/BRIEF.md
# Power-Up Strap Capture and Clock Pin Enable Controller

This block manages a group of dual-purpose pins that serve as configuration straps when power comes up and as clock outputs afterwards. Once the power-good input is seen high, the controller runs a timed sampling window of a fixed number of reference clock cycles. Throughout that window every pin driver stays three-stated, so an external pull resistor alone decides each pin's level. The clock path to each pin is also forced low during the window.

When the window expires, the synchronized pin levels are captured into a configuration register. In the same cycle the pin drivers are enabled and a sticky valid flag rises. From then on each pin carries its clock. The captured configuration and the enabled state persist until the asynchronous power-on reset is applied again. Neither later pin activity nor a glitch on power-good can change them.

The power-good input is treated as synchronous to the reference clock. The pin inputs pass through a two-stage synchronizer inside the block. The power-on reset asserts asynchronously and is released synchronously.

Top module: `strap_capture_ctrl`

## Requirements
- R1: While and after the power-on reset `rst_ni` is low, and until a capture happens, `cfg_o` is all zero, `cfg_valid_o` is 0, every bit of `pin_oe_o` is 0 and every bit of `pin_o` is 0.
- R2: If the first rising clock edge that samples `pwr_good_i` high is edge E0, and `pwr_good_i` stays high, then `cfg_valid_o` becomes 1 after edge E0+WINDOW_CYCLES and is still 0 after edge E0+WINDOW_CYCLES-1.
- R3: During the sampling window every bit of `pin_oe_o` is 0, which three-states the pin drivers.
- R4: Before capture, every bit of `pin_o` is 0 whatever the value of `clk_src_i`.
- R5: Bit i of `cfg_o` takes the level that bit i of `pin_i` had, held steady through the last three cycles of the window. A high level (pull-up) captures as 1 and a low level (pull-down) captures as 0.
- R6: `pin_oe_o` becomes all ones in the same cycle that `cfg_valid_o` rises, and it is never nonzero while `cfg_valid_o` is 0.
- R7: After capture, `pin_o[i]` equals `clk_src_i[i]` for every pin.
- R8: If `pwr_good_i` is sampled low during the window, no capture takes place. A full new window of WINDOW_CYCLES cycles starts from the next edge that samples `pwr_good_i` high.
- R9: After capture, changes on `pin_i` and on `pwr_good_i` leave `cfg_o`, `cfg_valid_o` and `pin_oe_o` unchanged.
- R10: Only `rst_ni` clears the captured configuration. After reset is released, a new window and capture follow the same rules as the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Power-on reset, asynchronous assert, active low |
| pwr_good_i | input | 1 | Supply-good indication, synchronous to clk_i |
| pin_i | input | NUM_PINS | Levels read back from the dual-purpose pins |
| clk_src_i | input | NUM_PINS | Internal clocks to be routed to the pins |
| pin_o | output | NUM_PINS | Data to the pin drivers, held low before capture |
| pin_oe_o | output | NUM_PINS | Per-pin driver enable, 1 drives the pin |
| cfg_o | output | NUM_PINS | Captured strap configuration |
| cfg_valid_o | output | 1 | Sticky flag, high once the configuration is captured |

## Verification
A wrong counter load or decrement shows up as `cfg_valid_o` rising one or more cycles early or late relative to the first power-good edge. The bench checks that edge exactly, on both sides. A state machine that leaves the window too early shows up at once as nonzero `pin_oe_o` or a toggling `pin_o` while power is still being sampled. A capture register that is not frozen shows up within one cycle of a pin change after enable, because `cfg_o` then differs from the value latched at the window's end. A missed restart after a power-good drop shows up as a capture that arrives one full window too early.

// File: rtl/strap_capture_pkg.sv
package strap_capture_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WINDOW = 2'd1,
    ST_RUN    = 2'd2
  } strap_state_e;

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = d_i;
    for (int s = 1; s < STAGES; s++) begin
      stage_d[s] = stage_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= stage_d[s];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/strap_window_timer.sv
module strap_window_timer #(
  parameter int WINDOW_CYCLES = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic dec_i,
  output logic zero_o
);

  localparam int CNT_W = (WINDOW_CYCLES > 1) ? $clog2(WINDOW_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WINDOW_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i | dec_i;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_d = LOAD_VAL;
    end else if (dec_i && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);

  AST_LOAD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == LOAD_VAL)); // R2

  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i && cnt_q == '0) |=> (cnt_q == '0)); // R2

endmodule

// File: rtl/strap_cfg_latch.sv
module strap_cfg_latch #(
  parameter int WIDTH = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] cfg_o,
  output logic             valid_o
);

  logic [WIDTH-1:0] cfg_q, cfg_d;
  logic             valid_q, valid_d;
  logic             cap_en;

  always_comb begin
    cap_en  = capture_i & ~valid_q;
    cfg_d   = d_i;
    valid_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      valid_q <= 1'b0;
    end else if (cap_en) begin
      cfg_q   <= cfg_d;
      valid_q <= valid_d;
    end
  end

  assign cfg_o   = cfg_q;
  assign valid_o = valid_q;

  AST_VALID_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> valid_q); // R9

  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> $stable(cfg_q)); // R9

  AST_CFG_ZERO_BEFORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> (cfg_q == '0)); // R1

endmodule

// File: rtl/strap_pin_drv.sv
module strap_pin_drv (
  input  logic en_i,
  input  logic clk_src_i,
  output logic pin_o,
  output logic oe_o
);

  assign pin_o = clk_src_i & en_i;
  assign oe_o  = en_i;

endmodule

// File: rtl/strap_capture_ctrl.sv
module strap_capture_ctrl
  import strap_capture_pkg::*;
#(
  parameter int NUM_PINS      = 5,
  parameter int WINDOW_CYCLES = 100000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                pwr_good_i,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] clk_src_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic [NUM_PINS-1:0] cfg_o,
  output logic                cfg_valid_o
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_n = rst_sync_q[1];

  // pin level synchronizer
  logic [NUM_PINS-1:0] pin_sync;

  strap_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .d_i    (pin_i),
    .q_o    (pin_sync)
  );

  // control state machine
  strap_state_e state_q, state_d;
  logic         tmr_load, tmr_dec, tmr_zero;
  logic         capture;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_dec  = 1'b0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (pwr_good_i) begin
          tmr_load = 1'b1;
          state_d  = ST_WINDOW;
        end
      end
      ST_WINDOW: begin
        if (!pwr_good_i) begin
          state_d = ST_IDLE;
        end else if (tmr_zero) begin
          capture = 1'b1;
          state_d = ST_RUN;
        end else begin
          tmr_dec = 1'b1;
        end
      end
      ST_RUN: begin
        state_d = ST_RUN;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  strap_window_timer #(
    .WINDOW_CYCLES (WINDOW_CYCLES)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .load_i (tmr_load),
    .dec_i  (tmr_dec),
    .zero_o (tmr_zero)
  );

  strap_cfg_latch #(
    .WIDTH (NUM_PINS)
  ) u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .capture_i (capture),
    .d_i       (pin_sync),
    .cfg_o     (cfg_o),
    .valid_o   (cfg_valid_o)
  );

  // per-pin output stage
  logic drv_en;
  assign drv_en = (state_q == ST_RUN);

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    strap_pin_drv u_drv (
      .en_i      (drv_en),
      .clk_src_i (clk_src_i[g]),
      .pin_o     (pin_o[g]),
      .oe_o      (pin_oe_o[g])
    );
  end

  AST_OE_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_n)
    (pin_oe_o != '0) |-> cfg_valid_o); // R6

  AST_OE_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_n)
    cfg_valid_o |-> (pin_oe_o == '1)); // R6

  AST_WINDOW_TRISTATE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == ST_WINDOW) |-> (pin_oe_o == '0)); // R3

  AST_PIN_LOW_BEFORE: assert property (@(posedge clk_i) disable iff (!rst_n)
    !cfg_valid_o |-> (pin_o == '0)); // R4

  AST_NO_CAPTURE_ON_DROP: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!cfg_valid_o && !pwr_good_i) |=> !cfg_valid_o); // R8

endmodule

// File: tb/strap_capture_ctrl_tb_top.sv
module strap_capture_ctrl_tb_top;

  localparam int NP = 5;
  localparam int W  = 40;

  logic          clk;
  logic          rst_n;
  logic          pg;
  logic [NP-1:0] pins;
  logic [NP-1:0] csrc;
  logic [NP-1:0] pin_o;
  logic [NP-1:0] oe;
  logic [NP-1:0] cfg;
  logic          valid;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  strap_capture_ctrl #(
    .NUM_PINS      (NP),
    .WINDOW_CYCLES (W),
    .SYNC_STAGES   (2)
  ) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pwr_good_i  (pg),
    .pin_i       (pins),
    .clk_src_i   (csrc),
    .pin_o       (pin_o),
    .pin_oe_o    (oe),
    .cfg_o       (cfg),
    .cfg_valid_o (valid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pg    = 1'b0;
    edges(3);
    rst_n = 1'b1;
    edges(5);
  endtask

  // R1: reset state
  task automatic t_reset();
    do_reset();
    csrc = '1;
    #1;
    chk(cfg == '0,  "R1 cfg",   32'(cfg),   0);
    chk(valid == 0, "R1 valid", 32'(valid), 0);
    chk(oe == '0,   "R1 oe",    32'(oe),    0);
    chk(pin_o == '0,"R1 pin",   32'(pin_o), 0);
  endtask

  // R2 R3 R4 R5 R6 R7: nominal window
  task automatic t_nominal(input logic [NP-1:0] strap);
    pins = strap;
    csrc = '1;
    edges(3);
    pg = 1'b1;
    edges(W);
    chk(valid == 0, "R2 early", 32'(valid), 0);
    chk(oe == '0,   "R3 oe in window", 32'(oe), 0);
    chk(pin_o == '0,"R4 pin held low", 32'(pin_o), 0);
    edges(1);
    chk(valid == 1, "R2 on time", 32'(valid), 1);
    chk(oe == '1,   "R6 oe with valid", 32'(oe), 32'h1f);
    chk(cfg == strap, "R5 captured", 32'(cfg), 32'(strap));
    csrc = 5'b10110;
    #1;
    chk(pin_o == 5'b10110, "R7 clocks routed", 32'(pin_o), 32'h16);
    csrc = 5'b01001;
    #1;
    chk(pin_o == 5'b01001, "R7 clocks routed", 32'(pin_o), 32'h09);
  endtask

  // R9: later activity ignored
  task automatic t_ignore(input logic [NP-1:0] strap);
    pins = ~strap;
    edges(4);
    chk(cfg == strap, "R9 pins ignored", 32'(cfg), 32'(strap));
    pg = 1'b0;
    edges(4);
    chk(valid == 1, "R9 pg drop valid", 32'(valid), 1);
    chk(oe == '1,   "R9 pg drop oe", 32'(oe), 32'h1f);
    chk(cfg == strap, "R9 pg drop cfg", 32'(cfg), 32'(strap));
    pg = 1'b1;
    edges(2);
  endtask

  // R8: power-good glitch restarts the window
  task automatic t_pg_drop();
    do_reset();
    pins = 5'b00011;
    pg   = 1'b1;
    edges(W - 5);
    pg = 1'b0;
    edges(3);
    chk(valid == 0, "R8 no capture on drop", 32'(valid), 0);
    chk(oe == '0,   "R8 oe stays off", 32'(oe), 0);
    pins = 5'b11100;
    edges(3);
    pg = 1'b1;
    edges(W);
    chk(valid == 0, "R8 full new window", 32'(valid), 0);
    edges(1);
    chk(valid == 1, "R8 capture after restart", 32'(valid), 1);
    chk(cfg == 5'b11100, "R8 new level", 32'(cfg), 32'h1c);
  endtask

  // R10: reset clears, new capture follows
  task automatic t_repower();
    do_reset();
    chk(valid == 0 && cfg == '0, "R10 cleared", {31'(cfg), valid}, 0);
    t_nominal(5'b10101);
  endtask

  initial begin
    rst_n = 1'b0;
    pg    = 1'b0;
    pins  = '0;
    csrc  = '0;
    t_reset();
    t_nominal(5'b01101);
    t_ignore(5'b01101);
    t_pg_drop();
    t_repower();
    t_reset();
    t_nominal(5'b00000);
    t_reset();
    t_nominal(5'b11111);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule